// File: doc/BRIEF.md
# Guard-Round-Sticky Rounding Stage

This block is the final rounding step of a floating-point datapath. Each operand arrives as a sign bit, a mantissa that carries two extra low-order bits, and a separate sticky bit that summarises every bit shifted away earlier. The two extra bits are the guard bit (the upper one) and the round bit (the lower one). The stage removes them and decides whether to add one unit in the last place. That decision follows a 2-bit rounding-mode input. The result, the increment decision and an inexact indication are registered and appear one clock after the operand is accepted.

The rounded mantissa is one bit wider than the kept field. An increment applied to an all-ones mantissa carries into that extra top bit, giving the value 2.0 in fixed-point terms. The stage leaves that value as it is, and the caller renormalises it and adjusts the exponent. A separate accumulated inexact flag collects every inexact result until the caller clears it.

Top module: `grs_round_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_mant, out_rnd_up, out_inexact and sticky_inexact are all zero after that edge.
- R2: When guard (in_mant[1]), round (in_mant[0]) and in_sticky are all zero, out_mant equals in_mant shifted right by two, and out_rnd_up and out_inexact are both zero.
- R3: out_inexact is 1 exactly when at least one of guard, round or sticky is 1.
- R4: With rnd_mode 2'b00 (nearest, ties to even), the stage increments only when guard is 1 and at least one of these is 1: round, sticky, or the lowest kept bit (in_mant[2]).
- R5: With rnd_mode 2'b01 (toward zero), the stage never increments.
- R6: With rnd_mode 2'b10 (toward +inf), the stage increments an inexact value only when in_sign is 0. With rnd_mode 2'b11 (toward -inf), it increments an inexact value only when in_sign is 1.
- R7: When the stage increments, out_rnd_up is 1 and out_mant equals (in_mant >> 2) + 1. Otherwise out_rnd_up is 0 and out_mant equals in_mant >> 2.
- R8: Incrementing an all-ones kept mantissa sets out_mant to 1 << MANT_W, with the top bit set and all other bits zero. No renormalisation is applied.
- R9: sticky_inexact becomes 1 on the edge that accepts an inexact operand and stays 1 until flag_clr is sampled high. If an inexact operand arrives on the same edge as flag_clr, the flag stays set.
- R10: Results appear one clock after acceptance: out_valid is 1 for exactly the cycle after each edge where in_valid is 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand is present this cycle |
| in_sign | input | 1 | Sign of the operand (1 = negative) |
| in_mant | input | MANT_W+2 | Mantissa; bit 1 is guard, bit 0 is round |
| in_sticky | input | 1 | OR of all bits discarded before this stage |
| rnd_mode | input | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| flag_clr | input | 1 | Clears the accumulated inexact flag |
| out_valid | output | 1 | Registered result is valid |
| out_mant | output | MANT_W+1 | Rounded mantissa; top bit is the carry into the next integer position |
| out_rnd_up | output | 1 | An increment was applied to this result |
| out_inexact | output | 1 | This result lost nonzero bits |
| sticky_inexact | output | 1 | Accumulated inexact flag |

## Verification
The bench tests exact ties under nearest-even with both odd and even low bits. It also tests the cases where only the sticky bit is set and only the round bit is set. A design that ignored sticky, or that rounded ties away from zero, would return a result one ulp off. It runs the directed modes with both signs, since swapping the two directed modes inverts the increment decision. It forces an all-ones mantissa to carry out, which catches an adder that drops the carry. It also checks a flag clear arriving in the same cycle as a new inexact result, where a clear-wins design would lose the event.

// File: rtl/grs_pkg.sv
// Shared definitions for the guard-round-sticky rounding stage.
package grs_pkg;
    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'b00,
        RND_ZERO      = 2'b01,
        RND_POS_INF   = 2'b10,
        RND_NEG_INF   = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/grs_decide.sv
// Increment decision for one operand.
// Inputs: sign, lowest kept bit, guard, round, sticky and the mode.
// Outputs: whether to add one ulp, and whether any discarded bit was set.
// Assumes all four mode encodings are legal; nearest is the fallback.
module grs_decide
    import grs_pkg::*;
(
    input  logic      sign,
    input  logic      lsb,
    input  logic      guard,
    input  logic      rnd,
    input  logic      sticky,
    input  rnd_mode_e mode,
    output logic      inc,
    output logic      inexact
);
    // Detect lost bits, then pick the increment rule for the mode.
    always_comb begin
        inexact = guard | rnd | sticky;
        inc     = 1'b0;
        if (inexact) begin
            unique case (mode)
                RND_ZERO:    inc = 1'b0;
                RND_POS_INF: inc = ~sign;
                RND_NEG_INF: inc = sign;
                default:     inc = guard & (rnd | sticky | lsb);
            endcase
        end
    end
endmodule

// File: rtl/grs_incr.sv
// Adds the increment decision to the truncated mantissa.
// The result is one bit wider, so a carry out stays visible to the caller.
module grs_incr #(
    parameter int MANT_W = 24
) (
    input  logic [MANT_W-1:0] trunc,
    input  logic              inc,
    output logic [MANT_W:0]   sum
);
    localparam int SUM_W = MANT_W + 1;

    // Zero-extend and add one ulp when requested.
    always_comb begin
        sum = {1'b0, trunc} + SUM_W'(inc);
    end
endmodule

// File: rtl/grs_round_unit.sv
// Rounding stage with a one-cycle latency.
// It drops the guard and round bits, applies the mode's increment rule
// and registers the result. It never renormalises: a carry out appears
// in the top bit of out_mant. The accumulated inexact flag is cleared
// only by flag_clr, and a new inexact result on the same edge wins over it.
// Assumes a synchronous, active-low reset.
module grs_round_unit
    import grs_pkg::*;
#(
    parameter int MANT_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sign,
    input  logic [MANT_W+1:0] in_mant,
    input  logic              in_sticky,
    input  logic [1:0]        rnd_mode,
    input  logic              flag_clr,
    output logic              out_valid,
    output logic [MANT_W:0]   out_mant,
    output logic              out_rnd_up,
    output logic              out_inexact,
    output logic              sticky_inexact
);
    localparam int IN_W = MANT_W + 2;

    logic [MANT_W-1:0] trunc;
    logic              inc;
    logic              inexact;
    logic [MANT_W:0]   sum;

    // Kept mantissa bits once guard and round are removed.
    always_comb trunc = in_mant[IN_W-1:2];

    grs_decide u_decide (
        .sign    (in_sign),
        .lsb     (in_mant[2]),
        .guard   (in_mant[1]),
        .rnd     (in_mant[0]),
        .sticky  (in_sticky),
        .mode    (rnd_mode_e'(rnd_mode)),
        .inc     (inc),
        .inexact (inexact)
    );

    grs_incr #(.MANT_W(MANT_W)) u_incr (
        .trunc (trunc),
        .inc   (inc),
        .sum   (sum)
    );

    // Register the result of each accepted operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_mant    <= '0;
            out_rnd_up  <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mant    <= sum;
                out_rnd_up  <= inc;
                out_inexact <= inexact;
            end
        end
    end

    // Accumulate the inexact flag; a new event overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_inexact <= 1'b0;
        end else begin
            sticky_inexact <= (sticky_inexact & ~flag_clr) | (in_valid & inexact);
        end
    end
endmodule

// File: rtl/grs_round_chk.sv
// Property checker for grs_round_unit, attached with bind below.
module grs_round_chk #(
    parameter int MANT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sign,
    input logic [MANT_W+1:0] in_mant,
    input logic              in_sticky,
    input logic [1:0]        rnd_mode,
    input logic              flag_clr,
    input logic              out_valid,
    input logic [MANT_W:0]   out_mant,
    input logic              out_rnd_up,
    input logic              out_inexact,
    input logic              sticky_inexact
);
    // R1
    rst_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_mant == '0 && !out_rnd_up && !sticky_inexact));

    // R2
    exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=>
        (!out_rnd_up && !out_inexact && out_mant == {1'b0, $past(in_mant[MANT_W+1:2])}));

    // R5
    toward_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_mode == 2'b01) |=> !out_rnd_up);

    // R6
    pos_inf_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_mode == 2'b10 && in_sign) |=> !out_rnd_up);

    // R6
    neg_inf_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rnd_mode == 2'b11 && !in_sign) |=> !out_rnd_up);

    // R7
    up_needs_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rnd_up) |-> out_inexact);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_mant[1:0] != 2'b00 || in_sticky)) |=> sticky_inexact);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_inexact && !flag_clr) |=> sticky_inexact);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

bind grs_round_unit grs_round_chk #(.MANT_W(MANT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_sign        (in_sign),
    .in_mant        (in_mant),
    .in_sticky      (in_sticky),
    .rnd_mode       (rnd_mode),
    .flag_clr       (flag_clr),
    .out_valid      (out_valid),
    .out_mant       (out_mant),
    .out_rnd_up     (out_rnd_up),
    .out_inexact    (out_inexact),
    .sticky_inexact (sticky_inexact)
);

// File: tb/sim_grs_round_unit.sv
module sim_grs_round_unit;
    localparam int MW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_sign;
    logic [MW+1:0] in_mant;
    logic          in_sticky;
    logic [1:0]    rnd_mode;
    logic          flag_clr;
    logic          out_valid;
    logic [MW:0]   out_mant;
    logic          out_rnd_up;
    logic          out_inexact;
    logic          sticky_inexact;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic flag_model = 1'b0;

    always #2 clk = ~clk;

    grs_round_unit #(.MANT_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_mant(in_mant), .in_sticky(in_sticky), .rnd_mode(rnd_mode),
        .flag_clr(flag_clr), .out_valid(out_valid), .out_mant(out_mant),
        .out_rnd_up(out_rnd_up), .out_inexact(out_inexact),
        .sticky_inexact(sticky_inexact)
    );

    // Expected result, packed as {inexact, up, mant}.
    function automatic logic [MW+2:0] model(input logic s, input logic [MW+1:0] m,
                                            input logic st, input logic [1:0] md);
        logic g, r, lsb, ix, up;
        logic [MW:0] q;
        g = m[1]; r = m[0]; lsb = m[2];
        ix = g | r | st;
        up = 1'b0;
        if (ix) begin
            if (md == 2'b00)      up = g && (r || st || lsb);
            else if (md == 2'b10) up = !s;
            else if (md == 2'b11) up = s;
        end
        q = {1'b0, m[MW+1:2]} + (up ? 1 : 0);
        return {ix, up, q};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operand, optionally with a clear, then check the registered result.
    task automatic apply(input string req, input logic s, input logic [MW+1:0] m,
                         input logic st, input logic [1:0] md, input logic clr);
        logic [MW+2:0] e;
        @(negedge clk);
        in_valid = 1'b1; in_sign = s; in_mant = m; in_sticky = st;
        rnd_mode = md; flag_clr = clr;
        e = model(s, m, st, md);
        flag_model = (flag_model & ~clr) | e[MW+2];
        @(posedge clk); #1;
        in_valid = 1'b0; flag_clr = 1'b0;
        check({req, " R10 valid"}, 64'(out_valid), 64'd1);
        check({req, " mant"}, 64'(out_mant), 64'(e[MW:0]));
        check({req, " R7 up"}, 64'(out_rnd_up), 64'(e[MW+1]));
        check({req, " R3 inexact"}, 64'(out_inexact), 64'(e[MW+2]));
        check({req, " R9 flag"}, 64'(sticky_inexact), 64'(flag_model));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [MW+1:0] ones;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_mant = '0;
        in_sticky = 1'b0; rnd_mode = 2'b00; flag_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset mant", 64'(out_mant), 64'd0);
        check("R1 reset flags", 64'({out_rnd_up, out_inexact, sticky_inexact}), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 idle valid", 64'(out_valid), 64'd0);

        // R2 exact value in every mode
        for (int md = 0; md < 4; md++)
            apply("R2 exact", 1'b1, 26'h2AB_CDE0 & ~26'h3, 1'b0, 2'(md), 1'b0);
        check("R2 exact mant", 64'(out_mant), 64'h0AA_F378);
        // R4 ties and near cases
        apply("R4 tie even", 1'b0, {24'h000010, 2'b10}, 1'b0, 2'b00, 1'b0);
        check("R4 tie even stays", 64'(out_mant), 64'h10);
        apply("R4 tie odd", 1'b0, {24'h000011, 2'b10}, 1'b0, 2'b00, 1'b0);
        check("R4 tie odd bumps", 64'(out_mant), 64'h12);
        apply("R4 guard sticky", 1'b0, {24'h000010, 2'b10}, 1'b1, 2'b00, 1'b0);
        apply("R4 round only", 1'b0, {24'h000011, 2'b01}, 1'b0, 2'b00, 1'b0);
        apply("R4 sticky only", 1'b1, {24'h000011, 2'b00}, 1'b1, 2'b00, 1'b0);
        // R5 toward zero
        apply("R5 zero", 1'b0, {24'h123457, 2'b11}, 1'b1, 2'b01, 1'b0);
        check("R5 no up", 64'(out_rnd_up), 64'd0);
        // R6 directed modes, both signs
        apply("R6 pos plus", 1'b0, {24'h000020, 2'b01}, 1'b0, 2'b10, 1'b0);
        apply("R6 pos minus", 1'b1, {24'h000020, 2'b01}, 1'b0, 2'b10, 1'b0);
        apply("R6 neg minus", 1'b1, {24'h000020, 2'b00}, 1'b1, 2'b11, 1'b0);
        apply("R6 neg plus", 1'b0, {24'h000020, 2'b00}, 1'b1, 2'b11, 1'b0);
        // R8 carry out to the next integer position
        ones = '1;
        apply("R8 carry", 1'b0, ones, 1'b0, 2'b00, 1'b0);
        check("R8 carry mant", 64'(out_mant), 64'h100_0000);
        // R9 clear, then clear together with a new inexact result
        apply("R9 clear exact", 1'b0, 26'h100, 1'b0, 2'b00, 1'b1);
        check("R9 cleared", 64'(sticky_inexact), 64'd0);
        apply("R9 set", 1'b0, 26'h101, 1'b0, 2'b01, 1'b0);
        apply("R9 clear and set", 1'b0, 26'h102, 1'b0, 2'b01, 1'b1);
        check("R9 set wins", 64'(sticky_inexact), 64'd1);
        @(negedge clk); flag_clr = 1'b1;
        @(posedge clk); #1; flag_clr = 1'b0;
        flag_model = 1'b0;
        check("R9 idle clear", 64'(sticky_inexact), 64'd0);

        // Random operands
        for (int i = 0; i < 3000; i++) begin
            logic [MW+1:0] m;
            m = 26'($urandom);
            if (($urandom % 8) == 0) m[MW+1:2] = '1;
            apply("R4 R6 R7 random", 1'($urandom), m, 1'(($urandom % 3) == 0),
                  2'($urandom), 1'(($urandom % 16) == 0));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule